// File: doc/BRIEF.md
# Platform System Control Registers

A byte-wide register block on a small synchronous port bus that carries the platform's miscellaneous control and identification ports. One port at 0x0092 holds the soft-reset request and the byte-order mode. A window of ports from 0x0800 up to 0x0851 holds:

- a disk-activity indicator bit;
- a 4-bit cache-control field;
- the I/O map mode bit, which the address translation logic reads;
- two write-triggered pulse outputs that toggle the locks of an external non-volatile memory;
- a set of hard-wired identification bytes.

A host issues one access per cycle. An access is a port address with a read strobe, a write strobe or both. Write effects land on the clock edge that samples the write strobe. Read data is registered and appears after the edge that samples the read strobe, and it is held until the next read. A one-cycle error pulse marks any access to a port that has no meaning for that kind of access, which makes a decode fault visible at once.

Top module: `sysctl_regs`

## Requirements
- R1: A write to port 0x0092 sets soft_rst_o to data bit 0 from the write edge on. The output is high when the bit is 1 and low when it is 0.
- R2: A write to port 0x0092 sets le_mode_o to data bit 1. A read of port 0x0092 returns 0x00.
- R3: A write to port 0x0808 sets disk_led_o to data bit 0.
- R4: A write to port 0x081C stores data bits 3:0 on cache_ctl_o. A read of 0x081C returns that nibble in bits 3:0 with bits 7:4 zero.
- R5: A write to port 0x0850 stores data bit 0 on map_sparse_o. A read of 0x0850 returns that bit in bit 0 with all other bits zero.
- R6: A write to 0x0810 raises lock1_pulse_o, and a write to 0x0812 raises lock2_pulse_o. Each pulse lasts exactly the one cycle after the write edge.
- R7: Reads return fixed bytes at these ports: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R8: A read of any other port returns 0xFF. This includes 0x0808, 0x0812, 0x0814 and addresses outside both ranges. A write to any port not named in R1 to R6 leaves every output and every stored bit unchanged.
- R9: While rst_ni is low and after its release, every output is zero: the soft reset is off and the map mode is contiguous.
- R10: rdata_o is loaded on the edge that samples rd_i high and keeps its value while rd_i is low.
- R11: decode_err_o is high for the cycle after an edge that samples a read of a port not named in R2, R4, R5 or R7. It is also high for the cycle after a write to a port not named in R1 to R6, other than the read-only ports 0x0800, 0x0802 and 0x0803.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Port address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| soft_rst_o | output | 1 | Soft-reset request |
| le_mode_o | output | 1 | Little-endian mode flag |
| disk_led_o | output | 1 | Disk-activity indicator |
| cache_ctl_o | output | 4 | Cache-control field |
| map_sparse_o | output | 1 | I/O map mode (0 contiguous, 1 sparse) |
| lock1_pulse_o | output | 1 | Lock channel 1 toggle pulse |
| lock2_pulse_o | output | 1 | Lock channel 2 toggle pulse |
| decode_err_o | output | 1 | Undecoded-access pulse |

## Verification
The stored control bits drive outputs directly. A wrong stored bit therefore shows on its output pin in the cycle after the write that set it, and again on the next read-back of the same port. A decode fault shows in one of two ways: a wrong byte one cycle after a read, or an error pulse that is present when it should be absent (or absent when it should be present). A sweep that reads every port in the low 4 KB, and writes every port in the window with checks on all outputs, catches such a fault within one access of its cause.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [15:0] P_SPECIAL = 16'h0092;
  localparam logic [15:0] P_CPUCFG  = 16'h0800;
  localparam logic [15:0] P_FEAT    = 16'h0802;
  localparam logic [15:0] P_STAT    = 16'h0803;
  localparam logic [15:0] P_LED     = 16'h0808;
  localparam logic [15:0] P_EQUIP   = 16'h080C;
  localparam logic [15:0] P_LOCK1   = 16'h0810;
  localparam logic [15:0] P_LOCK2   = 16'h0812;
  localparam logic [15:0] P_KEY     = 16'h0818;
  localparam logic [15:0] P_CACHE   = 16'h081C;
  localparam logic [15:0] P_L2      = 16'h0823;
  localparam logic [15:0] P_MAP     = 16'h0850;

  typedef enum logic [1:0] {SRC_CONST, SRC_CACHE, SRC_MAP, SRC_NONE} rd_src_e;

  typedef struct packed {
    logic special;
    logic led;
    logic lock1;
    logic lock2;
    logic cache;
    logic map_mode;
    logic ro_quiet;
  } wr_hit_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rd_src_e           rd_src_o,
  output logic [DATA_W-1:0] rd_const_o,
  output logic              rd_known_o,
  output wr_hit_t           wr_hit_o,
  output logic              wr_known_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [15:0] a;
  assign a = 16'(addr_i);

  always_comb begin
    rd_src_o   = SRC_NONE;
    rd_const_o = ALL_ONES;
    unique case (a)
      P_SPECIAL: begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'h00); end
      P_CPUCFG:  begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'hEF); end
      P_FEAT:    begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'hAD); end
      P_STAT:    begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'hE0); end
      P_EQUIP:   begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'h3C); end
      P_LOCK1:   begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'h39); end
      P_KEY:     begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'h00); end
      P_L2:      begin rd_src_o = SRC_CONST; rd_const_o = DATA_W'(8'h03); end
      P_CACHE:   rd_src_o = SRC_CACHE;
      P_MAP:     rd_src_o = SRC_MAP;
      default:   ;
    endcase
  end

  assign rd_known_o = (rd_src_o != SRC_NONE);

  always_comb begin
    wr_hit_o          = '0;
    wr_hit_o.special  = (a == P_SPECIAL);
    wr_hit_o.led      = (a == P_LED);
    wr_hit_o.lock1    = (a == P_LOCK1);
    wr_hit_o.lock2    = (a == P_LOCK2);
    wr_hit_o.cache    = (a == P_CACHE);
    wr_hit_o.map_mode = (a == P_MAP);
    wr_hit_o.ro_quiet = (a == P_CPUCFG) || (a == P_FEAT) || (a == P_STAT);
  end

  assign wr_known_o = |wr_hit_o;
endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CACHE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  wr_hit_t            wr_hit_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               soft_rst_o,
  output logic               le_mode_o,
  output logic               disk_led_o,
  output logic [CACHE_W-1:0] cache_ctl_o,
  output logic               map_sparse_o,
  output logic               lock1_pulse_o,
  output logic               lock2_pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_rst_o   <= 1'b0;
      le_mode_o    <= 1'b0;
      disk_led_o   <= 1'b0;
      cache_ctl_o  <= '0;
      map_sparse_o <= 1'b0;
    end else if (wr_i) begin
      if (wr_hit_i.special) begin
        soft_rst_o <= wdata_i[0];
        le_mode_o  <= wdata_i[1];
      end
      if (wr_hit_i.led)      disk_led_o   <= wdata_i[0];
      if (wr_hit_i.cache)    cache_ctl_o  <= wdata_i[CACHE_W-1:0];
      if (wr_hit_i.map_mode) map_sparse_o <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock1_pulse_o <= 1'b0;
      lock2_pulse_o <= 1'b0;
    end else begin
      lock1_pulse_o <= wr_i && wr_hit_i.lock1;
      lock2_pulse_o <= wr_i && wr_hit_i.lock2;
    end
  end

  assert_soft_rst_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_hit_i.special) |=> (soft_rst_o == $past(wdata_i[0])));

  assert_lock1_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock1_pulse_o |-> $past(wr_i && wr_hit_i.lock1));

  assert_lock_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lock1_pulse_o, lock2_pulse_o}));

  assert_ro_write_inert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_hit_i.special && !wr_hit_i.led && !wr_hit_i.cache && !wr_hit_i.map_mode)
      |=> $stable({soft_rst_o, le_mode_o, disk_led_o, cache_ctl_o, map_sparse_o}));
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CACHE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  rd_src_e            rd_src_i,
  input  logic [DATA_W-1:0]  rd_const_i,
  input  logic [CACHE_W-1:0] cache_ctl_i,
  input  logic               map_sparse_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    unique case (rd_src_i)
      SRC_CONST: rd_next = rd_const_i;
      SRC_CACHE: rd_next = DATA_W'(cache_ctl_i);
      SRC_MAP:   rd_next = DATA_W'(map_sparse_i);
      default:   rd_next = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_next;
  end

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_cache_upper_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_src_i == SRC_CACHE) |=> (rdata_o[DATA_W-1:CACHE_W] == '0));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CACHE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               soft_rst_o,
  output logic               le_mode_o,
  output logic               disk_led_o,
  output logic [CACHE_W-1:0] cache_ctl_o,
  output logic               map_sparse_o,
  output logic               lock1_pulse_o,
  output logic               lock2_pulse_o,
  output logic               decode_err_o
);
  rd_src_e           rd_src;
  logic [DATA_W-1:0] rd_const;
  logic              rd_known;
  wr_hit_t           wr_hit;
  logic              wr_known;

  sysctl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .addr_i    (addr_i),
    .rd_src_o  (rd_src),
    .rd_const_o(rd_const),
    .rd_known_o(rd_known),
    .wr_hit_o  (wr_hit),
    .wr_known_o(wr_known)
  );

  sysctl_ctrl_regs #(.DATA_W(DATA_W), .CACHE_W(CACHE_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .wr_hit_i     (wr_hit),
    .wdata_i      (wdata_i),
    .soft_rst_o   (soft_rst_o),
    .le_mode_o    (le_mode_o),
    .disk_led_o   (disk_led_o),
    .cache_ctl_o  (cache_ctl_o),
    .map_sparse_o (map_sparse_o),
    .lock1_pulse_o(lock1_pulse_o),
    .lock2_pulse_o(lock2_pulse_o)
  );

  sysctl_rdmux #(.DATA_W(DATA_W), .CACHE_W(CACHE_W)) u_rdmux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .rd_src_i    (rd_src),
    .rd_const_i  (rd_const),
    .cache_ctl_i (cache_ctl_o),
    .map_sparse_i(map_sparse_o),
    .rdata_o     (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) decode_err_o <= 1'b0;
    else         decode_err_o <= (rd_i && !rd_known) || (wr_i && !wr_known);
  end

  assert_err_has_access_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_err_o |-> $past(rd_i || wr_i));

  assert_lock2_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock2_pulse_o && !(wr_i && addr_i == ADDR_W'(P_LOCK2))) |=> !lock2_pulse_o);
endmodule

// File: tb/sysctl_regs_test.sv
`timescale 1ns/1ps
module sysctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        srst, le, led, map_s, lk1, lk2, err;
  logic [3:0]  cache;

  int checks = 0;
  int errors = 0;

  logic       m_srst = 0, m_le = 0, m_led = 0, m_map = 0;
  logic [3:0] m_cache = '0;

  always #2 clk = ~clk;

  sysctl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .soft_rst_o(srst), .le_mode_o(le),
    .disk_led_o(led), .cache_ctl_o(cache), .map_sparse_o(map_s),
    .lock1_pulse_o(lk1), .lock2_pulse_o(lk2), .decode_err_o(err)
  );

  task automatic chk(string req, logic [15:0] a, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %h: actual %h expected %h", req, a, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'h0, m_cache};
      16'h0850: return {7'h0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic rd_known(logic [15:0] a);
    case (a)
      16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h080C, 16'h0810,
      16'h0818, 16'h0823, 16'h081C, 16'h0850: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic wr_known(logic [15:0] a);
    case (a)
      16'h0092, 16'h0808, 16'h0810, 16'h0812, 16'h081C, 16'h0850,
      16'h0800, 16'h0802, 16'h0803: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_outputs(string req, logic [15:0] a);
    chk({req, " R1 srst"}, a, {7'h0, srst}, {7'h0, m_srst});
    chk({req, " R2 le"}, a, {7'h0, le}, {7'h0, m_le});
    chk({req, " R3 led"}, a, {7'h0, led}, {7'h0, m_led});
    chk({req, " R4 cache"}, a, {4'h0, cache}, {4'h0, m_cache});
    chk({req, " R5 map"}, a, {7'h0, map_s}, {7'h0, m_map});
  endtask

  task automatic do_read(logic [15:0] a);
    logic [7:0] held;
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R7/R8 rdata", a, rdata, exp_rd(a));
    chk("R11 rd err", a, {7'h0, err}, {7'h0, !rd_known(a)});
    held = rdata;
    addr = 16'h0800;
    @(negedge clk);
    chk("R10 hold", a, rdata, held);
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    case (a)
      16'h0092: begin m_srst = d[0]; m_le = d[1]; end
      16'h0808: m_led = d[0];
      16'h081C: m_cache = d[3:0];
      16'h0850: m_map = d[0];
      default: ;
    endcase
    @(negedge clk);
    wr = 1'b0;
    check_outputs("R8 write", a);
    chk("R6 lock1", a, {7'h0, lk1}, {7'h0, a == 16'h0810});
    chk("R6 lock2", a, {7'h0, lk2}, {7'h0, a == 16'h0812});
    chk("R11 wr err", a, {7'h0, err}, {7'h0, !wr_known(a)});
    @(negedge clk);
    chk("R6 lock off", a, {6'h0, lk1, lk2}, 8'h00);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_outputs("R9 in reset", 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R9 after reset", 16'h0);
    chk("R9 rdata", 16'h0, rdata, 8'h00);
    chk("R9 pulses", 16'h0, {5'h0, lk1, lk2, err}, 8'h00);

    // R1 R2: both polarities
    do_write(16'h0092, 8'h01);
    do_write(16'h0092, 8'h02);
    do_write(16'h0092, 8'h03);
    do_write(16'h0092, 8'h00);
    do_read(16'h0092);
    // R3 R4 R5 with read-back
    do_write(16'h0808, 8'h01);
    do_write(16'h081C, 8'hA5);
    do_read(16'h081C);
    do_write(16'h0850, 8'hFF);
    do_read(16'h0850);
    do_write(16'h081C, 8'h3E);
    do_read(16'h081C);
    // R6
    do_write(16'h0810, 8'h00);
    do_write(16'h0812, 8'h00);

    // R7 R8 R11: read sweep of the low 4 KB
    for (int a = 0; a < 16'h1000; a++) do_read(16'(a));
    do_read(16'h8092);
    do_read(16'hF850);

    // R8: write sweep across the window with varied data
    for (int a = 16'h0800; a < 16'h0852; a++) do_write(16'(a), 8'(a * 37 + 5));
    for (int a = 16'h0800; a < 16'h0852; a++) do_read(16'(a));
    do_write(16'h0814, 8'hFF);
    do_write(16'h1092, 8'hFF);
    do_write(16'h0092, 8'hFD);
    do_read(16'h0092);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule